// File: doc/BRIEF.md
# Packed SIMD Add, Subtract and Compare ALU

This block is a single-stage arithmetic unit for 64-bit packed integer data. Each issue carries two 64-bit operands and a 5-bit opcode. The opcode selects three things at once: the lane width (8, 16 or 32 bits), the operation, and the overflow policy (wrap, signed clamp or unsigned clamp). Lanes are fully independent, so no carry or borrow ever crosses a lane boundary.

Compare operations return a per-lane mask instead of flags. A few scalar operations work on the low 32 bits only: a wrapping add and bitwise AND, OR and XOR. The result is registered and appears one clock after the issue together with a one-cycle valid strobe. An opcode outside the defined set produces a zero result and raises an illegal-operation flag.

Top module: `simd_alu`

## Requirements
- R1: Wrapping packed operations. Lane i of a lane width W occupies bits [i*W+W-1 : i*W] of each operand and of the result. Opcode 3 adds 8x8 lanes, 2 adds 4x16 lanes, 6 subtracts 8x8 lanes, 5 subtracts 4x16 lanes and 4 subtracts 2x32 lanes. Subtraction is a minus b. Each lane keeps only its low W bits, and no carry or borrow passes to a neighbouring lane.
- R2: Signed clamping. Opcodes 8 (add, 8-bit lanes), 7 (add, 16-bit lanes), 10 (subtract, 8-bit lanes) and 9 (subtract, 16-bit lanes) treat lanes as two's complement. A lane whose true result is above the most positive value returns that value, and one whose true result is below the most negative value returns that value.
- R3: Unsigned clamping. Opcodes 12 (add, 8-bit lanes), 11 (add, 16-bit lanes), 14 (subtract, 8-bit lanes) and 13 (subtract, 16-bit lanes) treat lanes as unsigned. An add that exceeds the lane range returns all ones, and a subtract whose result would be negative returns zero.
- R4: Equality compare. Opcodes 17 (8-bit lanes), 16 (16-bit lanes) and 15 (32-bit lanes) set a lane to all ones when the two operand lanes are equal, and to all zeros otherwise.
- R5: Greater-than compare. Opcodes 20 (8-bit lanes), 19 (16-bit lanes) and 18 (32-bit lanes) set a lane to all ones when the a lane, read as signed, is greater than the b lane, and to all zeros otherwise.
- R6: Scalar 32-bit operations use only bits [31:0] of the operands and return zero in result bits [63:32]. Opcode 1 is a wrapping add, 21 is AND, 22 is OR and 23 is XOR.
- R7: Opcodes 0 and 24 to 31 are illegal. An issue with one of them returns a zero result with out_illegal high. Every defined opcode returns with out_illegal low.
- R8: An issue with in_valid high loads the result, and out_valid goes high for exactly the following cycle. While in_valid is low, out_valid stays low and out_result and out_illegal hold their values whatever the other inputs do.
- R9: While rst_n is low and just after it is released, out_valid, out_result and out_illegal are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Issue strobe |
| in_op | input | 5 | Opcode (see R1 to R7) |
| in_a | input | 64 | Operand a (minuend, left side of compare) |
| in_b | input | 64 | Operand b |
| out_valid | output | 1 | Result strobe, one cycle after issue |
| out_result | output | 64 | Registered result |
| out_illegal | output | 1 | Registered illegal-opcode flag |

## Verification
The bench builds the block with its default parameters: a 64-bit datapath, a 5-bit opcode and lane units of 8, 16 and 32 bits. This width gives eight, four and two lanes. That is enough to place carries and borrows right at lane seams, and to drive every lane to both saturation bounds in the same vector. With the 5-bit opcode, the illegal codes at both ends of the space (0 and 31) and the first one past the defined set (24) can all be reached.

// File: rtl/simd_alu_pkg.sv
package simd_alu_pkg;

    localparam int OP_W = 5;

    typedef enum logic [OP_W-1:0] {
        OP_ADD_S32  = 5'd1,
        OP_ADD_W16  = 5'd2,
        OP_ADD_B8   = 5'd3,
        OP_SUB_D32  = 5'd4,
        OP_SUB_W16  = 5'd5,
        OP_SUB_B8   = 5'd6,
        OP_ADDS_W16 = 5'd7,
        OP_ADDS_B8  = 5'd8,
        OP_SUBS_W16 = 5'd9,
        OP_SUBS_B8  = 5'd10,
        OP_ADDU_W16 = 5'd11,
        OP_ADDU_B8  = 5'd12,
        OP_SUBU_W16 = 5'd13,
        OP_SUBU_B8  = 5'd14,
        OP_CEQ_D32  = 5'd15,
        OP_CEQ_W16  = 5'd16,
        OP_CEQ_B8   = 5'd17,
        OP_CGT_D32  = 5'd18,
        OP_CGT_W16  = 5'd19,
        OP_CGT_B8   = 5'd20,
        OP_AND_S32  = 5'd21,
        OP_OR_S32   = 5'd22,
        OP_XOR_S32  = 5'd23
    } op_e;

    // Index into the lane-unit array: width = 8 << index
    typedef enum logic [1:0] {
        LW_8  = 2'd0,
        LW_16 = 2'd1,
        LW_32 = 2'd2
    } lane_e;

    typedef enum logic [2:0] {
        K_ADD = 3'd0,
        K_SUB = 3'd1,
        K_CEQ = 3'd2,
        K_CGT = 3'd3,
        K_AND = 3'd4,
        K_OR  = 3'd5,
        K_XOR = 3'd6
    } kind_e;

    typedef enum logic [1:0] {
        SAT_WRAP = 2'd0,
        SAT_SIGN = 2'd1,
        SAT_UNS  = 2'd2
    } sat_e;

    typedef struct packed {
        lane_e lw;
        kind_e kind;
        sat_e  sat;
        logic  scalar;
        logic  illegal;
    } ctrl_t;

endpackage

// File: rtl/simd_alu_decode.sv
module simd_alu_decode
    import simd_alu_pkg::*;
(
    input  logic [OP_W-1:0] op,
    output ctrl_t           ctrl
);

    always_comb begin
        ctrl         = '0;
        ctrl.lw      = LW_8;
        ctrl.kind    = K_ADD;
        ctrl.sat     = SAT_WRAP;
        ctrl.scalar  = 1'b0;
        ctrl.illegal = 1'b0;
        case (op)
            OP_ADD_S32:  begin ctrl.lw = LW_32; ctrl.kind = K_ADD; ctrl.scalar = 1'b1; end
            OP_ADD_W16:  begin ctrl.lw = LW_16; ctrl.kind = K_ADD; end
            OP_ADD_B8:   begin ctrl.lw = LW_8;  ctrl.kind = K_ADD; end
            OP_SUB_D32:  begin ctrl.lw = LW_32; ctrl.kind = K_SUB; end
            OP_SUB_W16:  begin ctrl.lw = LW_16; ctrl.kind = K_SUB; end
            OP_SUB_B8:   begin ctrl.lw = LW_8;  ctrl.kind = K_SUB; end
            OP_ADDS_W16: begin ctrl.lw = LW_16; ctrl.kind = K_ADD; ctrl.sat = SAT_SIGN; end
            OP_ADDS_B8:  begin ctrl.lw = LW_8;  ctrl.kind = K_ADD; ctrl.sat = SAT_SIGN; end
            OP_SUBS_W16: begin ctrl.lw = LW_16; ctrl.kind = K_SUB; ctrl.sat = SAT_SIGN; end
            OP_SUBS_B8:  begin ctrl.lw = LW_8;  ctrl.kind = K_SUB; ctrl.sat = SAT_SIGN; end
            OP_ADDU_W16: begin ctrl.lw = LW_16; ctrl.kind = K_ADD; ctrl.sat = SAT_UNS; end
            OP_ADDU_B8:  begin ctrl.lw = LW_8;  ctrl.kind = K_ADD; ctrl.sat = SAT_UNS; end
            OP_SUBU_W16: begin ctrl.lw = LW_16; ctrl.kind = K_SUB; ctrl.sat = SAT_UNS; end
            OP_SUBU_B8:  begin ctrl.lw = LW_8;  ctrl.kind = K_SUB; ctrl.sat = SAT_UNS; end
            OP_CEQ_D32:  begin ctrl.lw = LW_32; ctrl.kind = K_CEQ; end
            OP_CEQ_W16:  begin ctrl.lw = LW_16; ctrl.kind = K_CEQ; end
            OP_CEQ_B8:   begin ctrl.lw = LW_8;  ctrl.kind = K_CEQ; end
            OP_CGT_D32:  begin ctrl.lw = LW_32; ctrl.kind = K_CGT; end
            OP_CGT_W16:  begin ctrl.lw = LW_16; ctrl.kind = K_CGT; end
            OP_CGT_B8:   begin ctrl.lw = LW_8;  ctrl.kind = K_CGT; end
            OP_AND_S32:  begin ctrl.lw = LW_32; ctrl.kind = K_AND; ctrl.scalar = 1'b1; end
            OP_OR_S32:   begin ctrl.lw = LW_32; ctrl.kind = K_OR;  ctrl.scalar = 1'b1; end
            OP_XOR_S32:  begin ctrl.lw = LW_32; ctrl.kind = K_XOR; ctrl.scalar = 1'b1; end
            default:     ctrl.illegal = 1'b1;
        endcase
    end

endmodule

// File: rtl/simd_lane_unit.sv
module simd_lane_unit
    import simd_alu_pkg::*;
#(
    parameter int DATA_W = 64,
    parameter int LANE_W = 8
) (
    input  logic [DATA_W-1:0] a,
    input  logic [DATA_W-1:0] b,
    input  kind_e             kind,
    input  sat_e              sat,
    output logic [DATA_W-1:0] y
);

    localparam int N_LANES = DATA_W / LANE_W;
    localparam logic [LANE_W-1:0] S_MAX = {1'b0, {(LANE_W-1){1'b1}}};
    localparam logic [LANE_W-1:0] S_MIN = {1'b1, {(LANE_W-1){1'b0}}};
    localparam logic [LANE_W-1:0] U_MAX = {LANE_W{1'b1}};

    for (genvar g = 0; g < N_LANES; g++) begin : g_lane
        logic [LANE_W-1:0] la;
        logic [LANE_W-1:0] lb;
        logic [LANE_W:0]   ext;
        logic [LANE_W-1:0] raw;
        logic              s_ovf;
        logic              u_ovf;
        logic [LANE_W-1:0] lr;

        assign la = a[g*LANE_W +: LANE_W];
        assign lb = b[g*LANE_W +: LANE_W];

        always_comb begin
            // the extra top bit is the lane's own carry out or borrow
            if (kind == K_SUB) begin
                ext   = {1'b0, la} - {1'b0, lb};
                raw   = ext[LANE_W-1:0];
                s_ovf = (la[LANE_W-1] != lb[LANE_W-1]) && (raw[LANE_W-1] != la[LANE_W-1]);
            end else begin
                ext   = {1'b0, la} + {1'b0, lb};
                raw   = ext[LANE_W-1:0];
                s_ovf = (la[LANE_W-1] == lb[LANE_W-1]) && (raw[LANE_W-1] != la[LANE_W-1]);
            end
            u_ovf = ext[LANE_W];

            lr = raw;
            case (kind)
                K_ADD, K_SUB: begin
                    if (sat == SAT_SIGN && s_ovf) begin
                        lr = la[LANE_W-1] ? S_MIN : S_MAX;
                    end else if (sat == SAT_UNS && u_ovf) begin
                        lr = (kind == K_ADD) ? U_MAX : '0;
                    end
                end
                K_CEQ:   lr = (la == lb) ? U_MAX : '0;
                K_CGT:   lr = ($signed(la) > $signed(lb)) ? U_MAX : '0;
                default: lr = '0;
            endcase
        end

        assign y[g*LANE_W +: LANE_W] = lr;
    end

endmodule

// File: rtl/simd_alu.sv
module simd_alu
    import simd_alu_pkg::*;
#(
    parameter int DATA_W   = 64,
    parameter int SCALAR_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [OP_W-1:0]   in_op,
    input  logic [DATA_W-1:0] in_a,
    input  logic [DATA_W-1:0] in_b,
    output logic              out_valid,
    output logic [DATA_W-1:0] out_result,
    output logic              out_illegal
);

    localparam int N_WIDTHS = 3;

    typedef struct packed {
        logic              vld;
        logic              ill;
        logic [DATA_W-1:0] res;
    } stage_t;

    ctrl_t             ctrl;
    logic [DATA_W-1:0] lane_y [N_WIDTHS];
    logic [DATA_W-1:0] logic_y;
    logic [DATA_W-1:0] comb_y;
    stage_t            st_d;
    stage_t            st_q;

    simd_alu_decode u_dec (
        .op   (in_op),
        .ctrl (ctrl)
    );

    for (genvar w = 0; w < N_WIDTHS; w++) begin : g_width
        simd_lane_unit #(
            .DATA_W (DATA_W),
            .LANE_W (8 << w)
        ) u_lanes (
            .a    (in_a),
            .b    (in_b),
            .kind (ctrl.kind),
            .sat  (ctrl.sat),
            .y    (lane_y[w])
        );
    end

    always_comb begin
        case (ctrl.kind)
            K_AND:   logic_y = in_a & in_b;
            K_OR:    logic_y = in_a | in_b;
            K_XOR:   logic_y = in_a ^ in_b;
            default: logic_y = '0;
        endcase
    end

    always_comb begin
        comb_y = '0;
        if (!ctrl.illegal) begin
            if (ctrl.kind inside {K_AND, K_OR, K_XOR}) begin
                comb_y = logic_y;
            end else begin
                comb_y = lane_y[ctrl.lw];
            end
            if (ctrl.scalar) begin
                comb_y[DATA_W-1:SCALAR_W] = '0;
            end
        end
    end

    always_comb begin
        st_d     = st_q;
        st_d.vld = in_valid;
        if (in_valid) begin
            st_d.res = comb_y;
            st_d.ill = ctrl.illegal;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign out_valid   = st_q.vld;
    assign out_result  = st_q.res;
    assign out_illegal = st_q.ill;

endmodule

// File: rtl/simd_alu_chk.sv
module simd_alu_chk
    import simd_alu_pkg::*;
#(
    parameter int DATA_W = 64
) (
    input logic              clk,
    input logic              rst_n,
    input logic              in_valid,
    input logic [OP_W-1:0]   in_op,
    input logic [DATA_W-1:0] in_a,
    input logic [DATA_W-1:0] in_b,
    input logic              out_valid,
    input logic [DATA_W-1:0] out_result,
    input logic              out_illegal
);

    function automatic logic byte_masks_ok(input logic [DATA_W-1:0] v);
        logic ok = 1'b1;
        for (int i = 0; i < DATA_W / 8; i++) begin
            if (v[i*8 +: 8] != 8'h00 && v[i*8 +: 8] != 8'hFF) ok = 1'b0;
        end
        return ok;
    endfunction

    // R8
    issue_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);

    // R8
    idle_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid);

    // R8
    hold_result_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> ($stable(out_result) && $stable(out_illegal)));

    // R7
    illegal_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_illegal) |-> (out_result == '0));

    // R6
    scalar_upper_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && (in_op inside {OP_ADD_S32, OP_AND_S32, OP_OR_S32, OP_XOR_S32}))
        |=> (out_result[DATA_W-1:32] == '0));

    // R4
    ceq_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_op == OP_CEQ_B8) |=> byte_masks_ok(out_result));

    // R5
    cgt_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_op == OP_CGT_B8) |=> byte_masks_ok(out_result));

    // R5
    cgt_self_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_op == OP_CGT_B8 && in_a == in_b) |=> (out_result == '0));

endmodule

bind simd_alu simd_alu_chk #(.DATA_W(DATA_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .in_valid    (in_valid),
    .in_op       (in_op),
    .in_a        (in_a),
    .in_b        (in_b),
    .out_valid   (out_valid),
    .out_result  (out_result),
    .out_illegal (out_illegal)
);

// File: tb/simd_alu_bench.sv
`timescale 1ns/1ps
module simd_alu_bench;

    typedef struct packed {
        logic [4:0]  op;
        logic [63:0] a;
        logic [63:0] b;
        logic [63:0] exp;
        logic        ill;
    } vec_t;

    localparam int N_VEC = 26;
    localparam vec_t VECS [N_VEC] = '{
        // R1 byte add, carries stop at lane seams
        '{5'd3,  64'h01FF_7F80_0010_2030, 64'h0101_0180_00F0_E0D0, 64'h0200_8000_0000_0000, 1'b0},
        // R1 halfword add
        '{5'd2,  64'hFFFF_0001_8000_1234, 64'h0001_FFFF_8000_1111, 64'h0000_0000_0000_2345, 1'b0},
        // R1 word subtract, no borrow between halves
        '{5'd4,  64'h0000_0000_0000_0005, 64'h0000_0001_0000_0006, 64'hFFFF_FFFF_FFFF_FFFF, 1'b0},
        // R1 byte subtract
        '{5'd6,  64'h0010_2030_4050_6070, 64'h0101_0101_0101_0101, 64'hFF0F_1F2F_3F4F_5F6F, 1'b0},
        // R1 halfword subtract
        '{5'd5,  64'h0000_1234_8000_0001, 64'h0001_0034_0001_0002, 64'hFFFF_1200_7FFF_FFFF, 1'b0},
        // R2 signed byte add
        '{5'd8,  64'h7F80_0102_7050_C0F0, 64'h0180_0102_1050_C0F0, 64'h7F80_0204_7F7F_80E0, 1'b0},
        // R2 signed halfword add
        '{5'd7,  64'h7FFF_8000_1000_FFFF, 64'h0001_FFFF_2000_0001, 64'h7FFF_8000_3000_0000, 1'b0},
        // R2 signed halfword subtract
        '{5'd9,  64'h8000_7FFF_0005_0000, 64'h0001_FFFF_0007_8000, 64'h8000_7FFF_FFFE_7FFF, 1'b0},
        // R2 signed byte subtract
        '{5'd10, 64'h807F_0500_10F0_0000, 64'h01FF_0780_1010_0001, 64'h807F_FE7F_00E0_00FF, 1'b0},
        // R3 unsigned byte add
        '{5'd12, 64'hFF80_0102_F00F_0000, 64'h0180_0102_10F0_0000, 64'hFFFF_0204_FFFF_0000, 1'b0},
        // R3 unsigned halfword add
        '{5'd11, 64'hFFFF_8000_1234_0000, 64'h0001_8000_0001_0000, 64'hFFFF_FFFF_1235_0000, 1'b0},
        // R3 unsigned halfword subtract
        '{5'd13, 64'h0000_1234_8000_0005, 64'h0001_0234_7FFF_0006, 64'h0000_1000_0001_0000, 1'b0},
        // R3 unsigned byte subtract
        '{5'd14, 64'h0010_FF80_0102_0304, 64'h0101_01FF_0101_0405, 64'h000F_FE00_0001_0000, 1'b0},
        // R4 byte equality
        '{5'd17, 64'h0011_2233_4455_6677, 64'h0011_2200_4455_0077, 64'hFFFF_FF00_FFFF_00FF, 1'b0},
        // R4 halfword equality
        '{5'd16, 64'h1234_5678_0000_FFFF, 64'h1234_5679_0000_FFFE, 64'hFFFF_0000_FFFF_0000, 1'b0},
        // R4 word equality
        '{5'd15, 64'hDEAD_BEEF_0000_0001, 64'hDEAD_BEEF_0000_0002, 64'hFFFF_FFFF_0000_0000, 1'b0},
        // R5 signed byte greater-than
        '{5'd20, 64'h0180_7FFF_0005_807F, 64'h007F_8000_FF05_817E, 64'hFF00_FF00_FF00_00FF, 1'b0},
        // R5 signed halfword greater-than
        '{5'd19, 64'h8000_0001_FFFF_7FFF, 64'h7FFF_0000_FFFE_7FFF, 64'h0000_FFFF_FFFF_0000, 1'b0},
        // R5 signed word greater-than
        '{5'd18, 64'h0000_0000_8000_0000, 64'hFFFF_FFFF_7FFF_FFFF, 64'hFFFF_FFFF_0000_0000, 1'b0},
        // R6 scalar add, upper half dropped
        '{5'd1,  64'h1234_5678_FFFF_FFFF, 64'h1111_1111_0000_0002, 64'h0000_0000_0000_0001, 1'b0},
        // R6 scalar AND
        '{5'd21, 64'hFFFF_FFFF_F0F0_1234, 64'hFFFF_FFFF_FF00_00FF, 64'h0000_0000_F000_0034, 1'b0},
        // R6 scalar OR
        '{5'd22, 64'hFFFF_0000_F0F0_1200, 64'h0000_FFFF_0F00_0034, 64'h0000_0000_FFF0_1234, 1'b0},
        // R6 scalar XOR
        '{5'd23, 64'hAAAA_AAAA_FFFF_0000, 64'h5555_5555_0F0F_00FF, 64'h0000_0000_F0F0_00FF, 1'b0},
        // R7 illegal codes
        '{5'd0,  64'hFFFF_FFFF_FFFF_FFFF, 64'hFFFF_FFFF_FFFF_FFFF, 64'h0, 1'b1},
        '{5'd24, 64'h1234_5678_9ABC_DEF0, 64'h1111_1111_1111_1111, 64'h0, 1'b1},
        '{5'd31, 64'h8000_0000_0000_0001, 64'h0000_0000_0000_0001, 64'h0, 1'b1}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [4:0]  in_op = '0;
    logic [63:0] in_a = '0;
    logic [63:0] in_b = '0;
    logic        out_valid;
    logic [63:0] out_result;
    logic        out_illegal;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    simd_alu u_simd_alu (
        .clk         (clk),
        .rst_n       (rst_n),
        .in_valid    (in_valid),
        .in_op       (in_op),
        .in_a        (in_a),
        .in_b        (in_b),
        .out_valid   (out_valid),
        .out_result  (out_result),
        .out_illegal (out_illegal)
    );

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %h expected %h", tag, act, exp);
        end
    endtask

    // drive at a falling edge, the result is loaded at the next rising edge
    task automatic issue(input logic [4:0] op, input logic [63:0] a, input logic [63:0] b);
        @(negedge clk);
        in_valid = 1'b1;
        in_op    = op;
        in_a     = a;
        in_b     = b;
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R9 reset state
        chk("R9 valid in reset", {63'b0, out_valid}, 64'd0);
        chk("R9 result in reset", out_result, 64'd0);
        chk("R9 illegal in reset", {63'b0, out_illegal}, 64'd0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R9 valid after release", {63'b0, out_valid}, 64'd0);

        for (int i = 0; i < N_VEC; i++) begin
            issue(VECS[i].op, VECS[i].a, VECS[i].b);
            chk($sformatf("R8 valid vec %0d", i), {63'b0, out_valid}, 64'd1);
            chk($sformatf("R1-R7 result vec %0d op %0d", i, VECS[i].op), out_result, VECS[i].exp);
            chk($sformatf("R7 flag vec %0d", i), {63'b0, out_illegal}, {63'b0, VECS[i].ill});
        end

        // R8 one-cycle strobe, hold while idle under changing inputs
        issue(5'd3, 64'h0101_0101_0101_0101, 64'h0101_0101_0101_0101);
        in_op = 5'd0;
        in_a  = 64'hFFFF_FFFF_FFFF_FFFF;
        in_b  = 64'h1234_1234_1234_1234;
        @(negedge clk);
        chk("R8 strobe drops", {63'b0, out_valid}, 64'd0);
        chk("R8 result held", out_result, 64'h0202_0202_0202_0202);
        chk("R8 illegal held", {63'b0, out_illegal}, 64'd0);

        // R8 back-to-back issues
        @(negedge clk);
        in_valid = 1'b1;
        in_op = 5'd2; in_a = 64'h0001_0002_0003_0004; in_b = 64'h0001_0001_0001_0001;
        @(negedge clk);
        chk("R8 back-to-back first", out_result, 64'h0002_0003_0004_0005);
        in_op = 5'd30;
        @(negedge clk);
        in_valid = 1'b0;
        chk("R8 back-to-back valid", {63'b0, out_valid}, 64'd1);
        chk("R7 back-to-back illegal", {63'b0, out_illegal}, 64'd1);
        chk("R7 back-to-back zero", out_result, 64'd0);

        // R9 reset in mid-run clears the registers
        issue(5'd23, 64'h0, 64'h0000_0000_1234_5678);
        rst_n = 1'b0;
        @(negedge clk);
        chk("R9 result after reset", out_result, 64'd0);
        chk("R9 valid after reset", {63'b0, out_valid}, 64'd0);
        rst_n = 1'b1;

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule